// File: doc/BRIEF.md
# CDR Lock Acquisition and Loop-Gain Sequencer

This block steers a digital clock-and-data-recovery loop from power-up to steady tracking. While enabled, it counts early/late phase decisions in fixed windows of phase-detector transitions and reduces each window to a phase-error magnitude. At start it steps a frequency control word upward from a programmable low bound. Each window with a large error moves the word one step. When a window shows a magnitude below the near-lock threshold, the sweep stops and the word is held.

After the sweep halts, the sequencer lowers the loop-gain code in stages: wide for acquisition, moderate for frequency tracking, narrow for steady tracking. Each stage lasts until a programmable number of consecutive near-lock windows has passed. Lock is reported once moderate gain is reached. A run of consecutive windows whose magnitude exceeds a second, higher threshold counts as lost lock. The sequencer then clears the lock flag and restarts the sweep from the low bound. The loop filter that uses the control word and gain code is outside this block.

Top module: `cdr_lock_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released with `en` low, `state_o` is 0 (idle), `gain_code` is 0, `locked` is 0 and `retry_cnt` is 0.
- R2: One clock after `en` rises in idle, `state_o` becomes 1 (sweep), `ctrl_word` equals `sweep_lo`, `gain_code` is the wide code (6 by default) and `retry_cnt` is cleared to 0.
- R3: A window closes after WIN_LEN (64) counted transitions. A counted transition is a cycle with `upd_valid` high and exactly one of `upd_early`/`upd_late` high; a cycle with both or neither high is ignored. The window magnitude is |early count − late count|.
- R4: In sweep, a window whose magnitude is strictly below `near_thr` moves the state to 2 (acquire) and freezes `ctrl_word`. A magnitude equal to `near_thr` does not stop the sweep. `ctrl_word` does not change in states 2, 3 or 4.
- R5: In sweep, every window that is not near-lock advances `ctrl_word` by `sweep_step`. If the result would exceed `sweep_hi`, the word goes back to `sweep_lo` and `retry_cnt` rises by one, saturating at its all-ones value (15).
- R6: When a near-lock window arrives while the word sits at the top of the range, the halt wins: no wrap takes place and `retry_cnt` does not change.
- R7: In acquire, the gain code stays wide and `locked` stays low. After `dwell_win` consecutive near-lock windows (0 acts as 1), the state becomes 3 (frequency tracking), the gain code becomes moderate (4) and `locked` rises. A window that is not near-lock restarts the count.
- R8: In frequency tracking, after `dwell_win` further consecutive near-lock windows, the state becomes 4 (tracking) and the gain code becomes narrow (2).
- R9: In states 2, 3 and 4, four consecutive windows with magnitude above `lost_thr` return the state to sweep with `locked` low, `ctrl_word` equal to `sweep_lo` and the wide gain code. The sweep then finds the new lock point.
- R10: One clock after `en` is low, from any state, `state_o` is 0, `gain_code` is 0 and `locked` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Run enable; low forces idle |
| upd_valid | input | 1 | A phase decision is present this cycle |
| upd_early | input | 1 | Decision says sampling clock is early |
| upd_late | input | 1 | Decision says sampling clock is late |
| sweep_lo | input | CW_W | Lowest control word of the sweep |
| sweep_hi | input | CW_W | Highest control word allowed |
| sweep_step | input | CW_W | Increment per swept window |
| near_thr | input | MAG_W | Magnitude below which a window counts as near-lock |
| lost_thr | input | MAG_W | Magnitude above which a window counts as bad |
| dwell_win | input | DWELL_W | Near-lock windows needed per gain stage |
| ctrl_word | output | CW_W | Frequency control word to the loop |
| gain_code | output | GAIN_W | Loop-gain code to the loop filter |
| locked | output | 1 | Lock indicator |
| state_o | output | 3 | 0 idle, 1 sweep, 2 acquire, 3 frequency tracking, 4 tracking |
| retry_cnt | output | RETRY_W | Number of completed sweep passes without lock |

## Verification
Halting on near-lock and wrapping at the end of the range are both decided from the same closing window, so they can fall in one cycle. The bench places the loop stand-in's lock point on the top grid word of the range, which makes the near-lock window close exactly when advancing would overflow `sweep_hi`. The result is judged at the ports: the state must become acquire with the word still at the top value and `retry_cnt` still zero. A second meeting point is a threshold change during the sweep: a window magnitude equal to `near_thr` must keep sweeping, and one above it by one step of the threshold must halt.

// File: rtl/cdr_lock_pkg.sv
`timescale 1ns/1ps
package cdr_lock_pkg;
   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_SWEEP = 3'd1,
      ST_ACQ   = 3'd2,
      ST_FTRK  = 3'd3,
      ST_TRK   = 3'd4
   } lock_state_e;
endpackage

// File: rtl/cdr_err_window.sv
`timescale 1ns/1ps
module cdr_err_window #(
   parameter  int WIN_LEN = 64,
   localparam int MAG_W   = $clog2(WIN_LEN + 1),
   localparam int CNT_W   = $clog2(WIN_LEN)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             upd_valid,
   input  logic             upd_early,
   input  logic             upd_late,
   output logic             win_done,
   output logic [MAG_W-1:0] win_mag
);
   localparam logic signed [MAG_W:0] ONE = 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(WIN_LEN - 1);

   if (WIN_LEN < 2) begin : g_bad_len
      $error("cdr_err_window: WIN_LEN must be at least 2");
   end

   logic                    take;
   logic [CNT_W-1:0]        cnt;
   logic signed [MAG_W:0]   acc, acc_nx, abs_nx;

   assign take = upd_valid & (upd_early ^ upd_late);

   always_comb begin
      acc_nx = upd_early ? acc + ONE : acc - ONE;
      abs_nx = acc_nx[MAG_W] ? -acc_nx : acc_nx;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         cnt      <= '0;
         acc      <= '0;
         win_done <= 1'b0;
         win_mag  <= '0;
      end else if (take) begin
         if (cnt == LAST) begin
            cnt      <= '0;
            acc      <= '0;
            win_done <= 1'b1;
            win_mag  <= abs_nx[MAG_W-1:0];
         end else begin
            cnt      <= cnt + 1'b1;
            acc      <= acc_nx;
            win_done <= 1'b0;
         end
      end else begin
         win_done <= 1'b0;
      end
   end

   AST_WIN_MAG_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      win_done |-> (int'(win_mag) <= WIN_LEN)); // R3
   AST_WIN_MAG_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
      win_done |-> (win_mag[0] == 1'(WIN_LEN % 2))); // R3
endmodule

// File: rtl/cdr_sweep_gen.sv
`timescale 1ns/1ps
module cdr_sweep_gen #(
   parameter int CW_W      = 8,
   parameter int RETRY_W   = 4,
   parameter bit RETRY_SAT = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic               adv,
   input  logic               clr_retry,
   input  logic [CW_W-1:0]    lo,
   input  logic [CW_W-1:0]    hi,
   input  logic [CW_W-1:0]    step,
   output logic [CW_W-1:0]    word,
   output logic [RETRY_W-1:0] retry
);
   if (CW_W < 2 || RETRY_W < 1) begin : g_bad_w
      $error("cdr_sweep_gen: widths too small");
   end

   logic [CW_W:0] nxt;
   logic          at_end;
   logic          wrap;

   assign nxt    = {1'b0, word} + {1'b0, step};
   assign at_end = nxt > {1'b0, hi};
   assign wrap   = adv & at_end;

   always_ff @(posedge clk) begin
      if (!rst_n)    word <= '0;
      else if (load) word <= lo;
      else if (adv)  word <= at_end ? lo : nxt[CW_W-1:0];
   end

   if (RETRY_SAT) begin : g_retry_sat
      always_ff @(posedge clk) begin
         if (!rst_n || clr_retry)  retry <= '0;
         else if (wrap && retry != '1) retry <= retry + 1'b1;
      end
   end else begin : g_retry_wrap
      always_ff @(posedge clk) begin
         if (!rst_n || clr_retry) retry <= '0;
         else if (wrap)           retry <= retry + 1'b1;
      end
   end

   AST_RETRY_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(retry) |-> (retry == '0 || retry == $past(retry) + 1'b1)); // R5
endmodule

// File: rtl/cdr_lock_fsm.sv
`timescale 1ns/1ps
module cdr_lock_fsm
   import cdr_lock_pkg::*;
#(
   parameter int MAG_W       = 7,
   parameter int DWELL_W     = 4,
   parameter int GAIN_W      = 3,
   parameter int GAIN_WIDE   = 6,
   parameter int GAIN_MID    = 4,
   parameter int GAIN_NARROW = 2,
   parameter int LOSS_WINS   = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en,
   input  logic               win_done,
   input  logic [MAG_W-1:0]   win_mag,
   input  logic [MAG_W-1:0]   near_thr,
   input  logic [MAG_W-1:0]   lost_thr,
   input  logic [DWELL_W-1:0] dwell,
   output lock_state_e        state,
   output logic [GAIN_W-1:0]  gain,
   output logic               locked,
   output logic               sweep_load,
   output logic               sweep_adv,
   output logic               retry_clr
);
   localparam int LOSS_W = $clog2(LOSS_WINS + 1);
   localparam logic [LOSS_W-1:0] LOSS_LAST = LOSS_W'(LOSS_WINS - 1);

   if (GAIN_WIDE >= (1 << GAIN_W) || GAIN_NARROW < 1) begin : g_bad_gain
      $error("cdr_lock_fsm: gain codes out of range");
   end
   if (!(GAIN_WIDE > GAIN_MID && GAIN_MID > GAIN_NARROW)) begin : g_bad_order
      $error("cdr_lock_fsm: gain codes must fall from wide to narrow");
   end
   if (LOSS_WINS < 1) begin : g_bad_loss
      $error("cdr_lock_fsm: LOSS_WINS must be at least 1");
   end

   logic [DWELL_W-1:0] good_cnt;
   logic [DWELL_W:0]   good_nx;
   logic [LOSS_W-1:0]  bad_cnt;
   logic near, bad, in_lock, promote, lose_now;

   always_comb begin
      near     = win_mag < near_thr;
      bad      = win_mag > lost_thr;
      in_lock  = (state == ST_ACQ) || (state == ST_FTRK) || (state == ST_TRK);
      good_nx  = {1'b0, good_cnt} + 1'b1;
      promote  = good_nx >= {1'b0, dwell};
      lose_now = en && win_done && in_lock && bad && (bad_cnt == LOSS_LAST);
      retry_clr  = en && (state == ST_IDLE);
      sweep_load = retry_clr || lose_now;
      sweep_adv  = en && win_done && (state == ST_SWEEP) && !near;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || !en) begin
         state    <= ST_IDLE;
         gain     <= '0;
         locked   <= 1'b0;
         good_cnt <= '0;
         bad_cnt  <= '0;
      end else begin
         case (state)
            ST_IDLE: begin
               state <= ST_SWEEP;
               gain  <= GAIN_W'(GAIN_WIDE);
            end
            ST_SWEEP: begin
               good_cnt <= '0;
               bad_cnt  <= '0;
               if (win_done && near) state <= ST_ACQ;
            end
            ST_ACQ, ST_FTRK, ST_TRK: begin
               if (win_done) begin
                  if (lose_now) begin
                     state    <= ST_SWEEP;
                     gain     <= GAIN_W'(GAIN_WIDE);
                     locked   <= 1'b0;
                     good_cnt <= '0;
                     bad_cnt  <= '0;
                  end else begin
                     bad_cnt <= bad ? bad_cnt + 1'b1 : '0;
                     if (!near || state == ST_TRK) begin
                        good_cnt <= '0;
                     end else if (promote) begin
                        good_cnt <= '0;
                        locked   <= 1'b1;
                        if (state == ST_ACQ) begin
                           state <= ST_FTRK;
                           gain  <= GAIN_W'(GAIN_MID);
                        end else begin
                           state <= ST_TRK;
                           gain  <= GAIN_W'(GAIN_NARROW);
                        end
                     end else begin
                        good_cnt <= good_nx[DWELL_W-1:0];
                     end
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   AST_LOCK_ONLY_LATE: assert property (@(posedge clk) disable iff (!rst_n)
      locked |-> (state == ST_FTRK || state == ST_TRK)); // R7
   AST_ACQ_FROM_SWEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_ACQ && $past(state) != ST_ACQ) |-> $past(state) == ST_SWEEP); // R4
   AST_FTRK_FROM_ACQ: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_FTRK && $past(state) != ST_FTRK) |-> $past(state) == ST_ACQ); // R7
   AST_TRK_FROM_FTRK: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_TRK && $past(state) != ST_TRK) |-> $past(state) == ST_FTRK); // R8
   AST_LOSS_TO_SWEEP: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(locked) |-> (state == ST_SWEEP || state == ST_IDLE)); // R9
   AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(en) |-> (state == ST_IDLE && gain == '0 && !locked)); // R10
endmodule

// File: rtl/cdr_lock_ctrl.sv
`timescale 1ns/1ps
module cdr_lock_ctrl
   import cdr_lock_pkg::*;
#(
   parameter  int CW_W        = 8,
   parameter  int WIN_LEN     = 64,
   parameter  int DWELL_W     = 4,
   parameter  int RETRY_W     = 4,
   parameter  bit RETRY_SAT   = 1'b1,
   parameter  int GAIN_W      = 3,
   parameter  int GAIN_WIDE   = 6,
   parameter  int GAIN_MID    = 4,
   parameter  int GAIN_NARROW = 2,
   parameter  int LOSS_WINS   = 4,
   localparam int MAG_W       = $clog2(WIN_LEN + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en,
   input  logic               upd_valid,
   input  logic               upd_early,
   input  logic               upd_late,
   input  logic [CW_W-1:0]    sweep_lo,
   input  logic [CW_W-1:0]    sweep_hi,
   input  logic [CW_W-1:0]    sweep_step,
   input  logic [MAG_W-1:0]   near_thr,
   input  logic [MAG_W-1:0]   lost_thr,
   input  logic [DWELL_W-1:0] dwell_win,
   output logic [CW_W-1:0]    ctrl_word,
   output logic [GAIN_W-1:0]  gain_code,
   output logic               locked,
   output logic [2:0]         state_o,
   output logic [RETRY_W-1:0] retry_cnt
);
   logic             win_done;
   logic [MAG_W-1:0] win_mag;
   logic             sweep_load, sweep_adv, retry_clr;
   lock_state_e      st;

   cdr_err_window #(.WIN_LEN(WIN_LEN)) u_win (
      .clk(clk), .rst_n(rst_n), .clear(!en),
      .upd_valid(upd_valid), .upd_early(upd_early), .upd_late(upd_late),
      .win_done(win_done), .win_mag(win_mag)
   );

   cdr_sweep_gen #(.CW_W(CW_W), .RETRY_W(RETRY_W), .RETRY_SAT(RETRY_SAT)) u_sweep (
      .clk(clk), .rst_n(rst_n), .load(sweep_load), .adv(sweep_adv),
      .clr_retry(retry_clr), .lo(sweep_lo), .hi(sweep_hi), .step(sweep_step),
      .word(ctrl_word), .retry(retry_cnt)
   );

   cdr_lock_fsm #(
      .MAG_W(MAG_W), .DWELL_W(DWELL_W), .GAIN_W(GAIN_W),
      .GAIN_WIDE(GAIN_WIDE), .GAIN_MID(GAIN_MID), .GAIN_NARROW(GAIN_NARROW),
      .LOSS_WINS(LOSS_WINS)
   ) u_fsm (
      .clk(clk), .rst_n(rst_n), .en(en), .win_done(win_done), .win_mag(win_mag),
      .near_thr(near_thr), .lost_thr(lost_thr), .dwell(dwell_win),
      .state(st), .gain(gain_code), .locked(locked),
      .sweep_load(sweep_load), .sweep_adv(sweep_adv), .retry_clr(retry_clr)
   );

   assign state_o = st;

   AST_WORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_ACQ || st == ST_FTRK || st == ST_TRK) |-> $stable(ctrl_word)); // R4
   AST_SWEEP_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_SWEEP && $past(st) == ST_SWEEP && !$stable(ctrl_word))
      |-> (ctrl_word == $past(ctrl_word + sweep_step) || ctrl_word == sweep_lo)); // R5
   AST_TRK_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_TRK) |-> (gain_code == GAIN_W'(GAIN_NARROW))); // R8
endmodule

// File: tb/cdr_lock_ctrl_bench.sv
`timescale 1ns/1ps
module cdr_lock_ctrl_bench;
   localparam int WIN = 64;

   logic       clk = 1'b0;
   logic       rst_n, en, upd_valid, upd_early, upd_late;
   logic [7:0] sweep_lo, sweep_hi, sweep_step;
   logic [6:0] near_thr, lost_thr;
   logic [3:0] dwell_win;
   logic [7:0] ctrl_word;
   logic [2:0] gain_code;
   logic       locked;
   logic [2:0] state_o;
   logic [3:0] retry_cnt;

   int  checks = 0, errors = 0, cyc = 0;
   int  tgt = 0;
   bit  bias_mode = 1'b0;
   bit  done = 1'b0;

   always #5 clk = ~clk;
   always @(posedge clk) cyc++;

   cdr_lock_ctrl u_cdr_lock_ctrl (
      .clk(clk), .rst_n(rst_n), .en(en), .upd_valid(upd_valid),
      .upd_early(upd_early), .upd_late(upd_late), .sweep_lo(sweep_lo),
      .sweep_hi(sweep_hi), .sweep_step(sweep_step), .near_thr(near_thr),
      .lost_thr(lost_thr), .dwell_win(dwell_win), .ctrl_word(ctrl_word),
      .gain_code(gain_code), .locked(locked), .state_o(state_o),
      .retry_cnt(retry_cnt)
   );

   // Loop stand-in: the correct word is tgt; below it the clock reads early,
   // above it late; on it decisions balance (or carry a fixed 40/24 bias).
   initial begin
      int idx = 0;
      upd_valid = 1'b0; upd_early = 1'b0; upd_late = 1'b0;
      forever begin
         @(negedge clk);
         upd_valid = 1'b1;
         if (bias_mode && (cyc % 4 == 3)) begin
            upd_early = 1'b1; upd_late = 1'b1;       // ignored by R3
         end else begin
            if (int'(ctrl_word) < tgt)      begin upd_early = 1'b1; upd_late = 1'b0; end
            else if (int'(ctrl_word) > tgt) begin upd_early = 1'b0; upd_late = 1'b1; end
            else if (bias_mode)             begin upd_early = (idx % 8) < 5; upd_late = !((idx % 8) < 5); end
            else                            begin upd_early = idx[0]; upd_late = !idx[0]; end
            idx++;
         end
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wait_state(input int s, input int lim, input string req);
      int n = 0;
      while (int'(state_o) != s && n < lim) begin @(negedge clk); n++; end
      chk(int'(state_o) == s, req, int'(state_o), s);
   endtask

   task automatic disable_run();
      @(negedge clk); en = 1'b0;
      @(negedge clk);
      chk(state_o == 3'd0 && gain_code == 3'd0 && !locked, "R10 idle on disable",
          int'(state_o), 0);
   endtask

   initial begin
      int c0, c1, d, prev_w, prev_r, exp_w, exp_r, n, hits;
      rst_n = 1'b0; en = 1'b0;
      sweep_lo = 8'd16; sweep_hi = 8'd40; sweep_step = 8'd4;
      near_thr = 7'd8; lost_thr = 7'd32; dwell_win = 4'd2;
      repeat (3) @(negedge clk);
      chk(state_o == 3'd0 && gain_code == 3'd0 && !locked && retry_cnt == 4'd0,
          "R1 reset state", int'(state_o), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(state_o == 3'd0 && gain_code == 3'd0, "R1 idle while disabled", int'(gain_code), 0);

      // Every grid point as lock point; the top one meets the range end (R6)
      for (int t = 16; t <= 40; t += 4) begin
         tgt = t;
         en = 1'b1;
         @(negedge clk);
         chk(state_o == 3'd1, "R2 sweep after enable", int'(state_o), 1);
         chk(ctrl_word == 8'd16, "R2 sweep starts at low bound", int'(ctrl_word), 16);
         chk(gain_code == 3'd6, "R2 wide gain in sweep", int'(gain_code), 6);
         wait_state(2, 12 * WIN, "R4 sweep halts on near-lock");
         c0 = cyc;
         chk(int'(ctrl_word) == t, "R4 word frozen at lock point", int'(ctrl_word), t);
         chk(retry_cnt == 4'd0, (t == 40) ? "R6 halt beats wrap" : "R5 no wrap before lock",
             int'(retry_cnt), 0);
         chk(gain_code == 3'd6 && !locked, "R7 acquire wide, unlocked", int'(gain_code), 6);
         wait_state(3, 4 * WIN, "R7 reach frequency tracking");
         c1 = cyc;
         chk(c1 - c0 == 2 * WIN, "R7 acquire dwell length", c1 - c0, 2 * WIN);
         chk(gain_code == 3'd4 && locked, "R7 moderate gain and lock", int'(gain_code), 4);
         wait_state(4, 4 * WIN, "R8 reach tracking");
         chk(cyc - c1 == 2 * WIN, "R8 tracking dwell length", cyc - c1, 2 * WIN);
         chk(gain_code == 3'd2 && int'(ctrl_word) == t, "R8 narrow gain", int'(gain_code), 2);
         disable_run();
      end

      // Loss of lock after a frequency step, with a longer dwell (R9)
      dwell_win = 4'd3; tgt = 24; en = 1'b1;
      wait_state(2, 12 * WIN, "R4 lock to 24");
      c0 = cyc;
      wait_state(3, 5 * WIN, "R7 dwell three");
      chk(cyc - c0 == 3 * WIN, "R7 programmable dwell", cyc - c0, 3 * WIN);
      wait_state(4, 5 * WIN, "R8 tracking at 24");
      repeat (10) @(negedge clk);
      tgt = 32; c0 = cyc;
      wait_state(1, 8 * WIN, "R9 fall back to sweep");
      d = cyc - c0;
      chk(d >= 3 * WIN && d <= 5 * WIN + 2, "R9 loss after four bad windows", d, 4 * WIN);
      chk(!locked && ctrl_word == 8'd16 && gain_code == 3'd6, "R9 lock cleared, sweep reset",
          int'(ctrl_word), 16);
      wait_state(4, 20 * WIN, "R9 relock to tracking");
      chk(ctrl_word == 8'd32 && locked, "R9 relocked word", int'(ctrl_word), 32);
      disable_run();

      // Strict threshold and ignored decisions: on-target magnitude is 16 (R3, R4)
      dwell_win = 4'd2; bias_mode = 1'b1; tgt = 28; near_thr = 7'd16; en = 1'b1;
      n = 0; hits = 0;
      while (retry_cnt != 4'd2 && n < 4000) begin
         @(negedge clk); n++;
         if (state_o == 3'd2) hits++;
      end
      chk(hits == 0, "R4 magnitude equal to threshold keeps sweeping", hits, 0);
      chk(retry_cnt == 4'd2 && state_o == 3'd1, "R5 two passes counted", int'(retry_cnt), 2);
      near_thr = 7'd17;
      wait_state(2, 1500, "R3 magnitude 16 is below 17");
      chk(ctrl_word == 8'd28, "R3 halted on biased lock point", int'(ctrl_word), 28);
      disable_run();

      // Unreachable lock point: step order, wrap, retry saturation (R5)
      bias_mode = 1'b0; near_thr = 7'd8; tgt = 30; en = 1'b1;
      @(negedge clk);
      chk(retry_cnt == 4'd0, "R2 retry cleared on start", int'(retry_cnt), 0);
      prev_w = int'(ctrl_word); prev_r = int'(retry_cnt);
      for (int k = 0; k < 20; k++) begin
         n = 0;
         while (int'(ctrl_word) == prev_w && n < 100) begin @(negedge clk); n++; end
         exp_w = (prev_w == 40) ? 16 : prev_w + 4;
         exp_r = (prev_w == 40) ? prev_r + 1 : prev_r;
         chk(int'(ctrl_word) == exp_w, "R5 sweep step order", int'(ctrl_word), exp_w);
         chk(int'(retry_cnt) == exp_r, "R5 retry on wrap", int'(retry_cnt), exp_r);
         prev_w = int'(ctrl_word); prev_r = int'(retry_cnt);
      end
      n = 0;
      while (retry_cnt != 4'd15 && n < 9000) begin @(negedge clk); n++; end
      chk(retry_cnt == 4'd15, "R5 retry reaches maximum", int'(retry_cnt), 15);
      repeat (2 * 7 * WIN + 10) @(negedge clk);
      chk(retry_cnt == 4'd15 && state_o == 3'd1, "R5 retry saturates", int'(retry_cnt), 15);
      disable_run();

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(150000 * 10);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule